// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers 64 interrupt request lines into two banks of 32 and reduces them to one interrupt output for the processor. Every source is either edge-latched or level-sensitive. Which kind it is comes from a fixed bitmap per bank. For an edge-latched source, a rising edge sets a sticky event bit that stays set until software clears it. For a level-sensitive source, the source requests service for as long as its line is high. Each bank has a 32-bit enable mask. The output is the OR, over both banks, of the enabled pending bits.

Software reaches the block through a 32-bit register port with one-cycle read and write strobes and a 12-bit address. Through this port it can read the latched events, read and write the masks, clear events with a write of ones, and read the synchronised line levels. Data on the port is byte-reversed in both directions.

Top module: `irq_fold_ctrl`

## Requirements
- R1: After reset the events, mask and levels registers of both banks read zero, and `cpu_irq_o` is low.
- R2: Bank b occupies addresses 0x10+0x10*b (b = 0, 1). Within a bank, offset 0x0 reads events, 0x4 reads and writes the mask, 0x8 is write-only and clears events, and 0xC reads levels. Other offsets, and addresses outside 0x10 to 0x2F, read as zero and ignore writes.
- R3: Bus data is byte-reversed. Write data is swapped before it is used, and read data is swapped before it is returned. Bus byte 0 (bits 7:0) therefore maps to register bits 31:24.
- R4: Sources 0 to 31 drive bank 1 at bit n. Sources 32 to 63 drive bank 0 at bit n-32.
- R5: A rising edge on a source whose bit is not level-sensitive sets its event bit. The bit stays set after the line falls, until it is cleared.
- R6: Bank 1 bits 20 to 28 (bitmap 0x1FF00000) are level-sensitive and bank 0 has none. A level-sensitive bit never latches an event, and it requests service while its line is high.
- R7: A write to offset 0x8 clears each event bit written as one and leaves the other bits alone. Level-sensitive bits are unaffected, so an active level source keeps requesting service.
- R8: When a clear and a new rising edge hit the same event bit in the same cycle, the bit ends up set.
- R9: `cpu_irq_o` is a register holding the OR over both banks of (events | (levels & bitmap)) & mask.
- R10: A mask write changes `cpu_irq_o` in the cycle after the write and has no other effect.
- R11: The levels register follows the synchronised line state. When a line falls, its levels bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 64 | Interrupt request lines, asynchronous |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 12 | Register address |
| wdata_i | input | 32 | Write data, byte-reversed |
| rdata_o | output | 32 | Read data, byte-reversed, valid the cycle after rd_i |
| cpu_irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The properties expect `rd_i` and `wr_i` to be single-cycle strobes whose address and data are stable at the sampling edge. They also expect the request lines to change only between clock edges, so that the synchroniser latency is fixed. The bench drives every input on the falling edge, holds each source line for several cycles, and never overlaps a read with a write. To line up the same-cycle clear and edge case, the bench counts the two synchroniser stages and the edge-detect register. It then issues the clear so that it lands on the edge where the event is latched.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BANK_SPAN = 16;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [3:0] {
    OFF_EVENTS = 4'h0,
    OFF_MASK   = 4'h4,
    OFF_CLEAR  = 4'h8,
    OFF_LEVELS = 4'hC
  } reg_off_e;

  function automatic word_t swap_bytes(input word_t w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // fixed level-sensitive bitmap per bank
  function automatic word_t lvl_map_f(input int b);
    return (b == 1) ? 32'h1FF0_0000 : 32'h0000_0000;
  endfunction
endpackage

// File: rtl/irq_fold_sync.sv
module irq_fold_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_fold_bank.sv
module irq_fold_bank
  import irq_fold_pkg::*;
#(
  parameter word_t LVL_MAP = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t line_i,
  input  word_t rise_i,
  input  logic  mask_we_i,
  input  logic  clr_we_i,
  input  word_t wword_i,
  output word_t events_o,
  output word_t mask_o,
  output word_t levels_o,
  output logic  req_o
);
  word_t events_q, mask_q;
  word_t clr_bits, set_bits;

  assign clr_bits = clr_we_i ? (wword_i & ~LVL_MAP) : '0;
  assign set_bits = rise_i & ~LVL_MAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      events_q <= '0;
      mask_q   <= '0;
    end else begin
      events_q <= (events_q & ~clr_bits) | set_bits; // set wins
      if (mask_we_i) mask_q <= wword_i;
    end
  end

  assign events_o = events_q;
  assign mask_o   = mask_q;
  assign levels_o = line_i;
  assign req_o    = |((events_q | (line_i & LVL_MAP)) & mask_q);
endmodule

// File: rtl/irq_fold_regif.sv
module irq_fold_regif
  import irq_fold_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE      = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  word_t                wdata_i,
  input  word_t                events_i [NUM_BANKS],
  input  word_t                mask_i   [NUM_BANKS],
  input  word_t                levels_i [NUM_BANKS],
  output logic [NUM_BANKS-1:0] mask_we_o,
  output logic [NUM_BANKS-1:0] clr_we_o,
  output word_t                wword_o,
  output word_t                rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [ADDR_W-1:0]    rel_addr;
  logic [IDX_W-1:0]     bank_idx;
  logic [3:0]           reg_off;
  logic [NUM_BANKS-1:0] bank_sel;
  word_t                rd_word, rdata_q;

  assign rel_addr = addr_i - ADDR_W'(BASE);
  assign bank_idx = rel_addr[ADDR_W-1:4];
  assign reg_off  = rel_addr[3:0];
  assign wword_o  = swap_bytes(wdata_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign bank_sel[b]  = (bank_idx == IDX_W'(b));
    assign mask_we_o[b] = wr_i && bank_sel[b] && (reg_off == OFF_MASK);
    assign clr_we_o[b]  = wr_i && bank_sel[b] && (reg_off == OFF_CLEAR);
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        case (reg_off)
          OFF_EVENTS: rd_word = events_i[b];
          OFF_MASK:   rd_word = mask_i[b];
          OFF_LEVELS: rd_word = levels_i[b];
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= swap_bytes(rd_word);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
  import irq_fold_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_SRC    = NUM_BANKS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               cpu_irq_o
);
  logic [NUM_SRC-1:0]   line_w, rise_w;
  word_t                events_w [NUM_BANKS];
  word_t                mask_w   [NUM_BANKS];
  word_t                levels_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] req_w, mask_we_w, clr_we_w;
  word_t                wword_w;
  logic                 irq_q;

  irq_fold_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_src_i),
    .level_o (line_w),
    .rise_o  (rise_w)
  );

  // sources map to banks in reverse order
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned SLICE = NUM_BANKS - 1 - b;
    irq_fold_bank #(.LVL_MAP(lvl_map_f(b))) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (line_w[SLICE*DATA_W +: DATA_W]),
      .rise_i    (rise_w[SLICE*DATA_W +: DATA_W]),
      .mask_we_i (mask_we_w[b]),
      .clr_we_i  (clr_we_w[b]),
      .wword_i   (wword_w),
      .events_o  (events_w[b]),
      .mask_o    (mask_w[b]),
      .levels_o  (levels_w[b]),
      .req_o     (req_w[b])
    );
  end

  irq_fold_regif #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BASE(BANK_SPAN)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .events_i  (events_w),
    .mask_i    (mask_w),
    .levels_i  (levels_w),
    .mask_we_o (mask_we_w),
    .clr_we_o  (clr_we_w),
    .wword_o   (wword_w),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |req_w;
  end

  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/irq_fold_chk.sv
module irq_fold_chk
  import irq_fold_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cpu_irq_o,
  input word_t             events_i [NUM_BANKS],
  input word_t             mask_i   [NUM_BANKS],
  input word_t             levels_i [NUM_BANKS]
);
  localparam int unsigned TOP_ADDR = (NUM_BANKS + 1) * BANK_SPAN;
  logic any_req;

  always_comb begin
    any_req = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      any_req = any_req | (|((events_i[b] | (levels_i[b] & lvl_map_f(b))) & mask_i[b]));
  end

  AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cpu_irq_o == $past(any_req)); // R9

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i < ADDR_W'(BANK_SPAN) || addr_i >= ADDR_W'(TOP_ADDR))) |=> rdata_o == '0); // R2

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'((b + 1) * BANK_SPAN + 4);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'((b + 1) * BANK_SPAN + 8);

    AST_MASK_STORES_SWAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == MASK_A) |=> mask_i[b] == swap_bytes($past(wdata_i))); // R3

    AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == MASK_A) |=> $stable(mask_i[b])); // R10

    AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == CLR_A) |=> ($past(events_i[b]) & ~events_i[b]) == '0); // R5

    AST_LVL_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (events_i[b] & lvl_map_f(b)) == '0); // R6
  end
endmodule

bind irq_fold_ctrl irq_fold_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .cpu_irq_o (cpu_irq_o),
  .events_i  (events_w),
  .mask_i    (mask_w),
  .levels_i  (levels_w)
);

// File: tb/irq_fold_ctrl_tb_top.sv
module irq_fold_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_src_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cpu_irq_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_fold_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cpu_irq_o(cpu_irq_o)
  );

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // reg_val is the register value; the task swaps it onto the bus
  task automatic reg_wr(input logic [11:0] a, input logic [31:0] reg_val);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = bs(reg_val);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // returns the raw bus value
  task automatic bus_rd(input logic [11:0] a, output logic [31:0] bus_val);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    bus_val = rdata_o;
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    irq_src_i = '0; rst_ni = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    apply_reset();
    check("R1 irq", {31'b0, cpu_irq_o}, 32'h0);
    for (int b = 0; b < 2; b++) begin
      bus_rd(12'(16 * (b + 1) + 0),  v); check("R1 events", v, 32'h0);
      bus_rd(12'(16 * (b + 1) + 4),  v); check("R1 mask",   v, 32'h0);
      bus_rd(12'(16 * (b + 1) + 12), v); check("R1 levels", v, 32'h0);
    end
  endtask

  task automatic t_swap_map();
    logic [31:0] v;
    apply_reset();
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 12'h024; wdata_i = 32'h0000_00FF;
    @(negedge clk_i);
    wr_i = 1'b0;
    bus_rd(12'h024, v); check("R3 mask readback", v, 32'h0000_00FF);
    irq_src_i[62] = 1'b1; // bank 0 bit 30, mask 0
    wait_cyc(5);
    check("R4 bank0 unmasked no irq", {31'b0, cpu_irq_o}, 32'h0);
    bus_rd(12'h010, v); check("R4 bank0 events", v, 32'h0000_0040);
    irq_src_i[30] = 1'b1; // bank 1 bit 30, enabled by bus byte 0
    wait_cyc(5);
    check("R3 swapped mask enables", {31'b0, cpu_irq_o}, 32'h1);
    bus_rd(12'h020, v); check("R4 bank1 events", v, 32'h0000_0040);
    bus_rd(12'h02C, v); check("R11 bank1 levels", v, 32'h0000_0040);
  endtask

  task automatic t_edge_sticky();
    logic [31:0] v;
    apply_reset();
    irq_src_i[3] = 1'b1;
    wait_cyc(5);
    irq_src_i[3] = 1'b0;
    wait_cyc(5);
    bus_rd(12'h02C, v); check("R11 level falls", v, 32'h0);
    bus_rd(12'h020, v); check("R5 event sticky", v, bs(32'h0000_0008));
  endtask

  task automatic t_level_src();
    logic [31:0] v;
    apply_reset();
    reg_wr(12'h024, 32'h0020_0000);
    irq_src_i[21] = 1'b1;
    wait_cyc(5);
    bus_rd(12'h020, v); check("R6 no event", v, 32'h0);
    bus_rd(12'h02C, v); check("R6 level", v, bs(32'h0020_0000));
    check("R6 irq high", {31'b0, cpu_irq_o}, 32'h1);
    irq_src_i[21] = 1'b0;
    wait_cyc(5);
    check("R6 irq low", {31'b0, cpu_irq_o}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    apply_reset();
    irq_src_i[5] = 1'b1; irq_src_i[21] = 1'b1; irq_src_i[40] = 1'b1; irq_src_i[41] = 1'b1;
    wait_cyc(5);
    reg_wr(12'h024, 32'h0020_0000);
    reg_wr(12'h028, 32'hFFFF_FFFF);
    bus_rd(12'h020, v); check("R7 bank1 cleared", v, 32'h0);
    wait_cyc(1);
    check("R7 level still requests", {31'b0, cpu_irq_o}, 32'h1);
    reg_wr(12'h018, 32'h0000_0100);
    bus_rd(12'h010, v); check("R7 selective clear", v, bs(32'h0000_0200));
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    apply_reset();
    irq_src_i[7] = 1'b1;
    wait_cyc(5);
    irq_src_i[7] = 1'b0;
    wait_cyc(4);
    // rise latched on the third edge after the line changes
    irq_src_i[7] = 1'b1;
    wait_cyc(2);
    wr_i = 1'b1; addr_i = 12'h028; wdata_i = bs(32'h0000_0080);
    @(negedge clk_i);
    wr_i = 1'b0;
    bus_rd(12'h020, v); check("R8 set wins", v, bs(32'h0000_0080));
    reg_wr(12'h028, 32'h0000_0080);
    bus_rd(12'h020, v); check("R7 later clear", v, 32'h0);
  endtask

  task automatic t_mask_or();
    apply_reset();
    irq_src_i[33] = 1'b1; irq_src_i[2] = 1'b1;
    wait_cyc(5);
    check("R9 masked off", {31'b0, cpu_irq_o}, 32'h0);
    reg_wr(12'h014, 32'h0000_0002);
    check("R10 not yet", {31'b0, cpu_irq_o}, 32'h0);
    wait_cyc(1);
    check("R10 next cycle", {31'b0, cpu_irq_o}, 32'h1);
    reg_wr(12'h024, 32'h0000_0004);
    reg_wr(12'h014, 32'h0);
    wait_cyc(1);
    check("R9 bank1 alone", {31'b0, cpu_irq_o}, 32'h1);
    reg_wr(12'h024, 32'h0);
    wait_cyc(1);
    check("R9 both off", {31'b0, cpu_irq_o}, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    apply_reset();
    irq_src_i[1] = 1'b1;
    wait_cyc(5);
    reg_wr(12'h014, 32'hA5A5_0F0F);
    reg_wr(12'h034, 32'h1111_1111);
    reg_wr(12'h004, 32'h2222_2222);
    reg_wr(12'h015, 32'h3333_3333);
    reg_wr(12'h01C, 32'h4444_4444);
    reg_wr(12'h038, 32'hFFFF_FFFF);
    bus_rd(12'h014, v); check("R2 mask untouched", v, bs(32'hA5A5_0F0F));
    bus_rd(12'h020, v); check("R2 events untouched", v, bs(32'h0000_0002));
    bus_rd(12'h018, v); check("R2 clear reads zero", v, 32'h0);
    bus_rd(12'h011, v); check("R2 odd offset zero", v, 32'h0);
    bus_rd(12'h030, v); check("R2 above range zero", v, 32'h0);
    bus_rd(12'h000, v); check("R2 below range zero", v, 32'h0);
    bus_rd(12'h024, v); check("R2 bank1 mask untouched", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_swap_map();
    t_edge_sticky();
    t_level_src();
    t_clear();
    t_set_wins();
    t_mask_or();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule